// File: doc/BRIEF.md
# Quadrature Bus Clock and Memory Slot Interleaver

This block runs from a single fast reference clock and derives everything an 8-bit CPU bus needs for its timing. It produces two bus clocks, E and Q, each with a 50% duty cycle, with Q a quarter of a bus period ahead of E. It also produces a colour-subcarrier-rate tick and a pair of flags that split every bus cycle in two. The first half of the cycle, while E is low, belongs to video fetches. The second half, while E is high, belongs to the CPU and its peripherals. All outputs are flip-flop outputs clocked by the reference, so downstream logic can use them as clock enables without any new clock domain.

A programmable pre-divider feeds a fixed divide-by-four phase generator. Three speed modes choose the pre-divider ratio and the subcarrier ratio. A mode request may arrive at any time. It is held and takes effect only at the reference edge where E falls, so an E or Q phase is never cut short. The block also emits a one-cycle strobe when E rises and another when E falls, for use as bus-cycle markers.

Top module: `busclk_gen`

## Requirements
- R1: Within each bus cycle the (E,Q) pair steps through low/low, low/high, high/high, high/low in that order, one signal changing per step. Q rises a quarter bus period before E rises and falls a quarter period before E falls.
- R2: With `mode_req` = 2'b00 (normal speed), E has a period of 16 reference cycles, made of 8 cycles low and 8 cycles high.
- R3: With `mode_req` = 2'b01 (high speed), E has a period of 8 reference cycles, made of 4 low and 4 high.
- R4: With `mode_req` = 2'b10 (extended), E has a period of 16 reference cycles, made of 8 low and 8 high.
- R5: `csub_tick` is a one-cycle pulse every 4 reference cycles in normal and high-speed modes, and every 8 reference cycles in extended mode.
- R6: A mode request takes effect only at the reference edge where E falls. The value present at that edge wins, and `mode_active` reports the applied code. Code 2'b11 is reserved and applies normal speed, reported as 2'b00.
- R7: `video_slot` is high exactly while E is low, and `cpu_slot` is high exactly while E is high. The two flags are never high together.
- R8: `e_rise_stb` is high for exactly the first reference cycle in which E is high. `e_fall_stb` is high for exactly the first reference cycle in which E is low.
- R9: While `rst` is high at a clock edge, the following values are forced:
  - E, Q, both strobes and `csub_tick` go low.
  - `video_slot` goes high and `cpu_slot` goes low.
  - Normal speed (2'b00) is selected.
  - All divider counts restart from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested speed mode: 00 normal, 01 high speed, 10 extended, 11 reserved (normal) |
| bus_e | output | 1 | Bus clock E |
| bus_q | output | 1 | Quadrature bus clock Q, a quarter period ahead of E |
| e_rise_stb | output | 1 | One-cycle pulse in the first cycle E is high |
| e_fall_stb | output | 1 | One-cycle pulse in the first cycle E is low |
| csub_tick | output | 1 | Colour-subcarrier-rate tick |
| video_slot | output | 1 | Video memory slot active (E low) |
| cpu_slot | output | 1 | CPU memory slot active (E high) |
| mode_active | output | 2 | Speed mode currently applied |

## Verification
The assertions assume only two things about the inputs. First, `rst` is high at the first clock edge. Second, `mode_req` is a plain level sampled on the reference edge. Any code, including the reserved one, may appear at any edge, and the divider counters are cleared at each mode switch so that their range checks hold across switches. The stimulus holds reset for several edges and drives `mode_req` only at the falling reference edge. It sweeps every ordered pair of the four codes with the switch requested at each of 16 offsets after an E fall. It also issues two requests inside one bus cycle and asserts reset partway through an extended-mode cycle.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_FAST = 2'b01,
    MODE_EXT  = 2'b10
  } bus_mode_e;

  // The reserved code 2'b11 falls back to normal speed.
  function automatic bus_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b01:   return MODE_FAST;
      2'b10:   return MODE_EXT;
      default: return MODE_NORM;
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/busclk_mode_ctl.sv
module busclk_mode_ctl
  import busclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_req,
  input  logic       apply,
  output bus_mode_e  mode
);

  bus_mode_e mode_q;

  // The requested mode is held at the pin and sampled only at the E-fall boundary.
  always_ff @(posedge clk) begin
    if (rst)        mode_q <= MODE_NORM;
    else if (apply) mode_q <= decode_mode(mode_req);
  end

  assign mode = mode_q;

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(mode_q))
    else $error("mode changed away from an E-fall boundary");

  p_mode_code_r6: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'b11)
    else $error("reserved mode code applied");

endmodule

// File: rtl/busclk_prediv.sv
module busclk_prediv
  import busclk_pkg::*;
#(
  parameter int NORM_DIV = 4,
  parameter int FAST_DIV = 2,
  parameter int EXT_DIV  = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  bus_mode_e mode,
  input  logic      restart,
  output logic      adv
);

  localparam int MAX_DIV = max3(NORM_DIV, FAST_DIV, EXT_DIV);
  localparam int CW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    case (mode)
      MODE_FAST: lim = CW'(FAST_DIV - 1);
      MODE_EXT:  lim = CW'(EXT_DIV - 1);
      default:   lim = CW'(NORM_DIV - 1);
    endcase
  end

  // One enable every lim+1 reference cycles: four times the bus rate.
  assign adv = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (adv)       cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim)
    else $error("pre-divider count past its limit");

endmodule

// File: rtl/busclk_phasegen.sv
module busclk_phasegen (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic wrap,
  output logic e_out,
  output logic q_out,
  output logic rise_stb,
  output logic fall_stb,
  output logic vid_slot,
  output logic cpu_slot
);

  // Phase code 0..3: E = bit 1, Q = bit1 ^ bit0 (Gray order of E/Q).
  logic [1:0] ph_q;
  logic [1:0] ph_nxt;

  assign ph_nxt = adv ? ph_q + 2'd1 : ph_q;
  assign wrap   = adv && (ph_q == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= 2'b00;
      e_out    <= 1'b0;
      q_out    <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      vid_slot <= 1'b1;
      cpu_slot <= 1'b0;
    end else begin
      ph_q     <= ph_nxt;
      e_out    <= ph_nxt[1];
      q_out    <= ph_nxt[1] ^ ph_nxt[0];
      rise_stb <= adv && (ph_q == 2'b01);
      fall_stb <= wrap;
      vid_slot <= ~ph_nxt[1];
      cpu_slot <= ph_nxt[1];
    end
  end

  p_q_lead_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(e_out) |-> q_out)
    else $error("E rose while Q low");

  p_q_lead_fall_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(e_out) |-> !q_out)
    else $error("E fell while Q high");

  p_one_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    $countones({e_out, q_out} ^ $past({e_out, q_out})) <= 1)
    else $error("E and Q toggled together");

  p_slot_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot({vid_slot, cpu_slot}))
    else $error("slot flags not one-hot");

  p_slot_match_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_slot == e_out)
    else $error("cpu slot disagrees with E");

  p_rise_stb_r8: assert property (@(posedge clk) disable iff (rst)
    rise_stb == $rose(e_out))
    else $error("rise strobe misplaced");

  p_fall_stb_r8: assert property (@(posedge clk) disable iff (rst)
    fall_stb == $fell(e_out))
    else $error("fall strobe misplaced");

endmodule

// File: rtl/busclk_subtick.sv
module busclk_subtick #(
  parameter int LEG_DIV = 4,
  parameter int EXT_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_sel,
  input  logic clr,
  output logic tick
);

  localparam int MAX_DIV = (LEG_DIV > EXT_DIV) ? LEG_DIV : EXT_DIV;
  localparam int SW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic [SW-1:0] cnt_q;
  logic [SW-1:0] lim;

  assign lim = ext_sel ? SW'(EXT_DIV - 1) : SW'(LEG_DIV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= (cnt_q == lim);
      if (clr || cnt_q == lim) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  p_sub_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim)
    else $error("subcarrier count past its limit");

  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick)
    else $error("subcarrier tick longer than one cycle");

endmodule

// File: rtl/busclk_gen.sv
module busclk_gen
  import busclk_pkg::*;
#(
  parameter int NORM_PRE_DIV = 4,
  parameter int FAST_PRE_DIV = 2,
  parameter int EXT_PRE_DIV  = 4,
  parameter int LEG_SUB_DIV  = 4,
  parameter int EXT_SUB_DIV  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_req,
  output logic       bus_e,
  output logic       bus_q,
  output logic       e_rise_stb,
  output logic       e_fall_stb,
  output logic       csub_tick,
  output logic       video_slot,
  output logic       cpu_slot,
  output logic [1:0] mode_active
);

  bus_mode_e mode;
  logic      adv;
  logic      wrap;

  busclk_mode_ctl mode_i (
    .clk      (clk),
    .rst      (rst),
    .mode_req (mode_req),
    .apply    (wrap),
    .mode     (mode)
  );

  busclk_prediv #(
    .NORM_DIV (NORM_PRE_DIV),
    .FAST_DIV (FAST_PRE_DIV),
    .EXT_DIV  (EXT_PRE_DIV)
  ) prediv_i (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .restart (wrap),
    .adv     (adv)
  );

  busclk_phasegen phase_i (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .wrap     (wrap),
    .e_out    (bus_e),
    .q_out    (bus_q),
    .rise_stb (e_rise_stb),
    .fall_stb (e_fall_stb),
    .vid_slot (video_slot),
    .cpu_slot (cpu_slot)
  );

  busclk_subtick #(
    .LEG_DIV (LEG_SUB_DIV),
    .EXT_DIV (EXT_SUB_DIV)
  ) sub_i (
    .clk     (clk),
    .rst     (rst),
    .ext_sel (mode == MODE_EXT),
    .clr     (wrap),
    .tick    (csub_tick)
  );

  assign mode_active = mode;

endmodule

// File: tb/busclk_gen_tb_top.sv
module busclk_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_req = 2'b00;
  logic       bus_e, bus_q, e_rise_stb, e_fall_stb, csub_tick;
  logic       video_slot, cpu_slot;
  logic [1:0] mode_active;

  always #10 clk = ~clk;

  busclk_gen dut_i (
    .clk         (clk),
    .rst         (rst),
    .mode_req    (mode_req),
    .bus_e       (bus_e),
    .bus_q       (bus_q),
    .e_rise_stb  (e_rise_stb),
    .e_fall_stb  (e_fall_stb),
    .csub_tick   (csub_tick),
    .video_slot  (video_slot),
    .cpu_slot    (cpu_slot),
    .mode_active (mode_active)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dec(input logic [1:0] code);
    return (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : 0;
  endfunction

  // Half of the E period: pre-divider ratio times two phase steps.
  function automatic int half_of(input int m);
    return (m == 1) ? 4 : 8;
  endfunction

  function automatic int sub_of(input int m);
    return (m == 2) ? 8 : 4;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      1:       return "R3 high-speed E half period";
      2:       return "R4 extended E half period";
      default: return "R2 normal E half period";
    endcase
  endfunction

  // Mode code as seen by the design at the last rising edge.
  logic [1:0] req_s = 2'b00;
  always @(posedge clk) req_s <= mode_req;

  int cyc, run, qr, qf, model, last_tick;
  bit pe, pq, switched, tick_valid;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; run = 0; qr = 0; qf = 0; model = 0; last_tick = 0;
      pe = 0; pq = 0; switched = 0; tick_valid = 0;
    end else begin
      cyc++;
      chk(video_slot == !bus_e, "R7 video slot while E low", video_slot, !bus_e);
      chk(cpu_slot == bus_e, "R7 cpu slot while E high", cpu_slot, bus_e);
      chk(!(video_slot && cpu_slot), "R7 slots exclusive", video_slot && cpu_slot, 0);
      chk(e_rise_stb == (bus_e && !pe), "R8 rise strobe", e_rise_stb, bus_e && !pe);
      chk(e_fall_stb == (!bus_e && pe), "R8 fall strobe", e_fall_stb, !bus_e && pe);
      chk(!((bus_e != pe) && (bus_q != pq)), "R1 one signal per step", bus_q, pq);
      if (bus_q && !pq) qr = cyc;
      if (!bus_q && pq) qf = cyc;
      if (bus_e != pe) begin
        chk(run == half_of(model), tag_of(model), run, half_of(model));
        if (bus_e) begin
          chk(cyc - qr == half_of(model) / 2, "R1 Q rise leads E rise", cyc - qr, half_of(model) / 2);
        end else begin
          chk(cyc - qf == half_of(model) / 2, "R1 Q fall leads E fall", cyc - qf, half_of(model) / 2);
          if (dec(req_s) != model) switched = 1;
          model = dec(req_s);
        end
        run = 1;
      end else begin
        run++;
      end
      chk(int'(mode_active) == model, "R6 mode applied only at E fall", int'(mode_active), model);
      if (csub_tick) begin
        if (tick_valid && !switched)
          chk(cyc - last_tick == sub_of(model), "R5 subcarrier tick spacing", cyc - last_tick, sub_of(model));
        last_tick = cyc; tick_valid = 1; switched = 0;
      end
      pe = bus_e; pq = bus_q;
    end
  end

  task automatic wait_falls(input int n);
    repeat (n) begin
      do @(negedge clk); while (!e_fall_stb);
    end
  endtask

  task automatic reset_checks();
    chk(bus_e == 0, "R9 E low in reset", bus_e, 0);
    chk(bus_q == 0, "R9 Q low in reset", bus_q, 0);
    chk(video_slot == 1, "R9 video slot in reset", video_slot, 1);
    chk(cpu_slot == 0, "R9 cpu slot in reset", cpu_slot, 0);
    chk(e_rise_stb == 0 && e_fall_stb == 0, "R9 strobes low in reset", e_rise_stb | e_fall_stb, 0);
    chk(csub_tick == 0, "R9 tick low in reset", csub_tick, 0);
    chk(mode_active == 2'b00, "R9 normal mode in reset", mode_active, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_checks();
    rst = 1'b0;
    wait_falls(3);

    // Every ordered pair of codes, switch requested at every offset.
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int off = 0; off < 16; off++) begin
          mode_req = 2'(a);
          wait_falls(2);
          repeat (off) @(negedge clk);
          mode_req = 2'(b);
          wait_falls(2);
        end
      end
    end

    // Two requests in one bus cycle: the later one wins (R6).
    mode_req = 2'b00;
    wait_falls(2);
    repeat (2) @(negedge clk);
    mode_req = 2'b01;
    repeat (3) @(negedge clk);
    chk(mode_active == 2'b00, "R6 request held mid-cycle", mode_active, 0);
    mode_req = 2'b10;
    wait_falls(1);
    chk(mode_active == 2'b10, "R6 last request before boundary wins", mode_active, 2);
    wait_falls(2);

    // Reset partway through an extended-mode cycle.
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    reset_checks();
    rst = 1'b0;
    wait_falls(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule